// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This unit gathers the eleven interrupt causes of a serial port into one interrupt line. Four modem-line change pulses, a receive-timeout pulse and four receive-error pulses (framing, parity, break, overrun) are caught in sticky bits. Two further bits come from the fill levels of the receive and transmit FIFOs. They are compared against programmable fractional thresholds. These level bits set when a fill condition starts and drop by themselves when it ends.

Software sees five word locations: a level-select register, an enable mask, the raw status, the masked status (raw AND mask) and a write-one-to-clear register. All four status-type registers share the same bit layout. The combined interrupt output is the OR of the masked bits, registered once. FIFO storage, modem-line sampling and the timeout counter sit outside this unit and arrive as inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Each event pulse sets its raw status bit, and the bit stays set until it is cleared. Bit positions: ring 0, CTS 1, DCD 2, DSR 3, receive-level 4, transmit-level 5, receive-timeout 6, framing 7, parity 8, break 9, overrun 10. On `modemPulse`, bit i maps to raw bit i. On `errPulse`, bits 0..3 map to raw bits 7..10.
- R2: The mask register at offset 0x38 (bits [10:0]) is written and read at that offset. It changes only on a write there. The raw status reads at 0x3c. The masked status reads at 0x40 and equals raw AND mask.
- R3: A write to offset 0x44 clears every raw bit whose data bit is 1, and leaves the bits written 0 unchanged. Writing 0x7ff clears all bits. If an event arrives in the same cycle as the clear, the event wins.
- R4: The level-select register at 0x34 holds the receive code in bits [5:3] and the transmit code in bits [2:0]. Codes 0, 1, 2, 3 and 4 select 1/8, 1/4, 1/2, 3/4 and 7/8 of FIFO_DEPTH. With a depth of 16 these are 2, 4, 8, 12 and 14.
- R5: With FIFOs enabled, raw bit 4 sets in the cycle the receive count first reaches or exceeds the receive threshold. It clears by itself when the count drops below the threshold.
- R6: With FIFOs enabled, raw bit 5 sets in the cycle the transmit count first falls to or below the transmit threshold. It clears by itself when the count rises above the threshold.
- R7: Level codes 5, 6 and 7 act as code 2 (half depth).
- R8: With `fifoEn` low, raw bit 4 follows a receive count of one or more. Raw bit 5 follows a transmit count of zero.
- R9: `irqOut` is the OR of the masked status bits, delayed by one clock.
- R10: After reset, raw status and mask are zero, the level-select register reads 0x12 and `irqOut` is low.
- R11: Writes to the raw (0x3c) and masked (0x40) offsets have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 16 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 16 | Read data (combinational) |
| rxCount | input | CNT_W | Receive FIFO fill count |
| txCount | input | CNT_W | Transmit FIFO fill count |
| fifoEn | input | 1 | FIFOs enabled; low selects single-character mode |
| modemPulse | input | 4 | Modem change pulses: ring, CTS, DCD, DSR |
| rxTimeoutPulse | input | 1 | Receive-timeout pulse |
| errPulse | input | 4 | Error pulses: framing, parity, break, overrun |
| irqOut | output | 1 | Combined interrupt |

## Verification
A wrong sticky bit appears in the raw word one read after the clock edge that should have changed it. Through the mask it reaches `irqOut` one cycle later. A wrong edge detector for the level bits shows in one of three ways: the bit fails to set on a threshold crossing, it stays set after the count moves away, or it comes back after a software clear while the condition still holds. A wrong threshold decode moves the crossing by at least one count. The bench therefore steps each code through threshold-minus-one and threshold. Race errors between clear and set show at once in the raw word.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NUM_SRC = 11;
  localparam int LVL_W = 6;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h3c;
  localparam logic [ADDR_W-1:0] OFS_MIS   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h44;

  localparam logic [LVL_W-1:0] LEVEL_RST = 6'h12;

  localparam int BIT_RXLVL = 4;
  localparam int BIT_TXLVL = 5;
  localparam int BIT_RXTO  = 6;
  localparam int BIT_ERR0  = 7;

  typedef struct packed {
    logic wrLevel;
    logic wrMask;
    logic wrClear;
    logic rxSet;
    logic rxDrop;
    logic txSet;
    logic txDrop;
  } irqStrobe_t;
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] thr
);
  localparam int EIGHTH = FIFO_DEPTH / 8;
  localparam int QUART  = FIFO_DEPTH / 4;
  localparam int HALF   = FIFO_DEPTH / 2;
  localparam int THREEQ = (3 * FIFO_DEPTH) / 4;
  localparam int SEVENE = (7 * FIFO_DEPTH) / 8;

  always_comb begin
    case (code)
      3'd0:    thr = CNT_W'(EIGHTH);
      3'd1:    thr = CNT_W'(QUART);
      3'd2:    thr = CNT_W'(HALF);
      3'd3:    thr = CNT_W'(THREEQ);
      3'd4:    thr = CNT_W'(SEVENE);
      default: thr = CNT_W'(HALF);
    endcase
  end
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LVL_W-1:0]  levelReg,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              fifoEn,
  output irqStrobe_t        strobe
);
  logic [CNT_W-1:0] rxThr;
  logic [CNT_W-1:0] txThr;
  logic rxCond;
  logic txCond;
  logic rxPrev;
  logic txPrev;

  uart_irq_thresh #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uRxThr (
    .code(levelReg[5:3]), .thr(rxThr));
  uart_irq_thresh #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uTxThr (
    .code(levelReg[2:0]), .thr(txThr));

  always_comb begin
    rxCond = fifoEn ? (rxCount >= rxThr) : (rxCount != '0);
    txCond = fifoEn ? (txCount <= txThr) : (txCount == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPrev <= 1'b0;
      txPrev <= 1'b0;
    end else begin
      rxPrev <= rxCond;
      txPrev <= txCond;
    end
  end

  always_comb begin
    strobe.wrLevel = wrEn && (wrAddr == OFS_LEVEL);
    strobe.wrMask  = wrEn && (wrAddr == OFS_MASK);
    strobe.wrClear = wrEn && (wrAddr == OFS_CLR);
    strobe.rxSet   = rxCond && !rxPrev;
    strobe.rxDrop  = !rxCond;
    strobe.txSet   = txCond && !txPrev;
    strobe.txDrop  = !txCond;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [3:0]         modemPulse,
  input  logic               rxTimeoutPulse,
  input  logic [3:0]         errPulse,
  output logic [LVL_W-1:0]   levelReg,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [NUM_SRC-1:0] rawStat,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] dropVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] misStat;

  always_comb begin
    setVec = '0;
    setVec[3:0] = modemPulse;
    setVec[BIT_RXLVL] = strobe.rxSet;
    setVec[BIT_TXLVL] = strobe.txSet;
    setVec[BIT_RXTO] = rxTimeoutPulse;
    setVec[BIT_ERR0 +: 4] = errPulse;
    dropVec = '0;
    dropVec[BIT_RXLVL] = strobe.rxDrop;
    dropVec[BIT_TXLVL] = strobe.txDrop;
    clrVec = strobe.wrClear ? wrData[NUM_SRC-1:0] : '0;
    misStat = rawStat & maskReg;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gBit
    always_ff @(posedge clk) begin
      if (!rstN)
        rawStat[i] <= 1'b0;
      else if (setVec[i])
        rawStat[i] <= 1'b1;
      else if (clrVec[i] || dropVec[i])
        rawStat[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelReg <= LEVEL_RST;
      maskReg  <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (strobe.wrLevel) levelReg <= wrData[LVL_W-1:0];
      if (strobe.wrMask) maskReg <= wrData[NUM_SRC-1:0];
      irqOut <= |misStat;
    end
  end

  always_comb begin
    case (rdAddr)
      OFS_LEVEL: rdData = DATA_W'(levelReg);
      OFS_MASK:  rdData = DATA_W'(maskReg);
      OFS_RAW:   rdData = DATA_W'(rawStat);
      OFS_MIS:   rdData = DATA_W'(misStat);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              fifoEn,
  input  logic [3:0]        modemPulse,
  input  logic              rxTimeoutPulse,
  input  logic [3:0]        errPulse,
  output logic              irqOut
);
  irqStrobe_t strobe;
  logic [LVL_W-1:0]   levelReg;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] rawStat;

  uart_irq_ctl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .levelReg(levelReg), .rxCount(rxCount), .txCount(txCount),
    .fifoEn(fifoEn), .strobe(strobe));

  uart_irq_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .modemPulse(modemPulse),
    .rxTimeoutPulse(rxTimeoutPulse), .errPulse(errPulse),
    .levelReg(levelReg), .maskReg(maskReg), .rawStat(rawStat),
    .rdData(rdData), .irqOut(irqOut));
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       wrAddr,
  input logic [15:0]      wrData,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] txCount,
  input logic [3:0]       modemPulse,
  input logic [3:0]       errPulse,
  input logic [10:0]      rawStat,
  input logic [10:0]      maskReg,
  input logic             irqOut
);
  // R1: an overrun pulse must leave its sticky bit set
  p_event_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    errPulse[3] |=> rawStat[10]);

  // R2: mask changes only on a write to its offset
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 8'h38) |=> $stable(maskReg));

  // R3: a clear with no competing event drops the ring bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 8'h44 && wrData[0] && !modemPulse[0]) |=> !rawStat[0]);

  // R5: an empty receive FIFO never leaves the receive-level bit set
  p_rx_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |=> !rawStat[4]);

  // R6: a full transmit FIFO never leaves the transmit-level bit set
  p_tx_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CNT_W'(FIFO_DEPTH)) |=> !rawStat[5]);

  // R9: output trails the masked status by one clock
  p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(rawStat & maskReg)));
endmodule

bind uart_irq_ctrl uart_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rxCount(rxCount), .txCount(txCount), .modemPulse(modemPulse),
  .errPulse(errPulse), .rawStat(rawStat), .maskReg(maskReg), .irqOut(irqOut));

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic [15:0] rdData;
  logic [CW-1:0] rxCount = '0;
  logic [CW-1:0] txCount = CW'(DEPTH);
  logic fifoEn = 1'b1;
  logic [3:0] modemPulse = '0;
  logic rxTimeoutPulse = 1'b0;
  logic [3:0] errPulse = '0;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rxCount(rxCount), .txCount(txCount),
    .fifoEn(fifoEn), .modemPulse(modemPulse), .rxTimeoutPulse(rxTimeoutPulse),
    .errPulse(errPulse), .irqOut(irqOut));

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [7:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkReg(string tag, logic [7:0] a, logic [15:0] exp);
    logic [15:0] v;
    readReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    checkReg("R10 raw", 8'h3c, 16'h0);
    checkReg("R10 mask", 8'h38, 16'h0);
    checkReg("R10 level", 8'h34, 16'h12);
    check("R10 irq", {15'b0, irqOut}, 16'h0);
    checkReg("R11 unmapped read", 8'h00, 16'h0);
  endtask

  task automatic testEvents();
    for (int i = 0; i < 4; i++) begin
      modemPulse = 4'(1 << i); tick(); modemPulse = '0;
    end
    rxTimeoutPulse = 1'b1; tick(); rxTimeoutPulse = 1'b0;
    checkReg("R1 modem+timeout", 8'h3c, 16'h004f);
    for (int i = 0; i < 4; i++) begin
      errPulse = 4'(1 << i); tick(); errPulse = '0;
    end
    checkReg("R1 all events", 8'h3c, 16'h07cf);
    checkReg("R2 masked zero", 8'h40, 16'h0);
    check("R9 irq masked off", {15'b0, irqOut}, 16'h0);
  endtask

  task automatic testMask();
    writeReg(8'h38, 16'h0080);
    checkReg("R2 mask readback", 8'h38, 16'h0080);
    checkReg("R2 masked value", 8'h40, 16'h0080);
    check("R9 irq not yet", {15'b0, irqOut}, 16'h0);
    tick();
    check("R9 irq after one clock", {15'b0, irqOut}, 16'h1);
  endtask

  task automatic testClear();
    writeReg(8'h44, 16'h0080);
    checkReg("R3 partial clear", 8'h3c, 16'h074f);
    check("R9 irq still high", {15'b0, irqOut}, 16'h1);
    tick();
    check("R9 irq drops", {15'b0, irqOut}, 16'h0);
    writeReg(8'h44, 16'h07ff);
    checkReg("R3 clear all", 8'h3c, 16'h0);
    errPulse = 4'b1000;
    writeReg(8'h44, 16'h0400);
    errPulse = '0;
    checkReg("R3 set beats clear", 8'h3c, 16'h0400);
    writeReg(8'h44, 16'h07ff);
  endtask

  task automatic testIgnored();
    modemPulse = 4'b0010; tick(); modemPulse = '0;
    writeReg(8'h3c, 16'h07ff);
    writeReg(8'h40, 16'h07ff);
    checkReg("R11 raw write ignored", 8'h3c, 16'h0002);
    checkReg("R11 mask untouched", 8'h38, 16'h0080);
    writeReg(8'h44, 16'h07ff);
  endtask

  task automatic testRxLevel();
    rxCount = '0;
    writeReg(8'h34, {10'b0, 3'd1, 3'd0});
    rxCount = 3; tick();
    checkReg("R5 below threshold", 8'h3c, 16'h0);
    rxCount = 4; tick();
    checkReg("R5 reach threshold", 8'h3c, 16'h0010);
    rxCount = 5; tick();
    checkReg("R5 above threshold", 8'h3c, 16'h0010);
    writeReg(8'h44, 16'h0010);
    checkReg("R5 cleared while held", 8'h3c, 16'h0);
    tick();
    checkReg("R5 no re-set while held", 8'h3c, 16'h0);
    rxCount = 2; tick();
    rxCount = 4; tick();
    checkReg("R5 re-crossing sets", 8'h3c, 16'h0010);
    rxCount = 3; tick();
    checkReg("R5 self clear", 8'h3c, 16'h0);
    rxCount = '0;
  endtask

  task automatic testRxCodes();
    int thr [5] = '{2, 4, 8, 12, 14};
    for (int c = 0; c < 5; c++) begin
      rxCount = '0;
      writeReg(8'h34, 16'((c << 3) | 0));
      checkReg("R4 level readback", 8'h34, 16'((c << 3)));
      rxCount = CW'(thr[c] - 1); tick();
      checkReg("R4 code minus one", 8'h3c, 16'h0);
      rxCount = CW'(thr[c]); tick();
      checkReg("R4 code threshold", 8'h3c, 16'h0010);
    end
    rxCount = '0; tick();
  endtask

  task automatic testReserved();
    for (int c = 5; c < 8; c++) begin
      rxCount = '0;
      writeReg(8'h34, 16'(c << 3));
      rxCount = 7; tick();
      checkReg("R7 reserved below half", 8'h3c, 16'h0);
      rxCount = 8; tick();
      checkReg("R7 reserved at half", 8'h3c, 16'h0010);
    end
    rxCount = '0; tick();
  endtask

  task automatic testTxLevel();
    writeReg(8'h34, {10'b0, 3'd0, 3'd3});
    txCount = 13; tick();
    checkReg("R6 above threshold", 8'h3c, 16'h0);
    txCount = 12; tick();
    checkReg("R6 falls to threshold", 8'h3c, 16'h0020);
    txCount = 5; tick();
    checkReg("R6 stays below", 8'h3c, 16'h0020);
    txCount = CW'(DEPTH); tick();
    checkReg("R6 self clear", 8'h3c, 16'h0);
  endtask

  task automatic testNoFifo();
    rxCount = '0;
    fifoEn = 1'b0; tick();
    checkReg("R8 idle", 8'h3c, 16'h0);
    rxCount = 1; tick();
    checkReg("R8 one char", 8'h3c, 16'h0010);
    rxCount = '0; txCount = '0; tick();
    checkReg("R8 holding empty", 8'h3c, 16'h0020);
    txCount = 1; tick();
    checkReg("R8 holding loaded", 8'h3c, 16'h0);
    txCount = CW'(DEPTH); fifoEn = 1'b1; tick();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testEvents();
    testMask();
    testClear();
    testIgnored();
    testRxLevel();
    testRxCodes();
    testReserved();
    testTxLevel();
    testNoFifo();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule